// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block handles even parity for a multiplexed 32-bit address/data bus, in both the initiating and the responding role. On every clock where an address phase or a completed data transfer takes place, the block takes in the address/data word and the command/byte-enable nibble and computes their parity. If the block itself is driving that phase, it drives the computed parity bit on the following clock. If another agent is driving, it compares that clock's incoming parity bit against the computed value.

A mismatch on a received address always raises the system-error output for one clock. A mismatch on a received data phase raises the data-parity-error output for one clock, but only when the error-response enable bit of the command register is set. Both kinds of mismatch set a sticky status flag, which software clears by writing a 1 to it. The transaction state machine sits outside this block and supplies the qualifiers: a valid-phase strobe, the address/data distinction and the drive direction.

Top module: `pci_parity_unit`

## Requirements
- R1: If a clock has `phaseValid`=1 and `srcPhase`=1, then on the next clock `parOe` is 1 and `parOut` equals the XOR of all 32 `adIn` bits and all 4 `cbeIn` bits, which makes the total count of ones even.
- R2: `parOe` is 0 on any clock whose previous clock had no valid phase, or had a phase the block did not source.
- R3: If a clock has `phaseValid`=1, `addrPhase`=1 and `srcPhase`=0, and `parIn` on the next clock differs from the even parity of that phase, then `serrN` is 0 for exactly the clock after that, whatever the value of `perrRespEn`.
- R4: If a received data phase (`phaseValid`=1, `addrPhase`=0, `srcPhase`=0) mismatches in the same way while `perrRespEn`=1 on the parity clock, then `perrN` is 0 for exactly one clock, the clock after the parity clock.
- R5: A received data-phase mismatch while `perrRespEn`=0 leaves `perrN` at 1, but still sets `detParErr`.
- R6: An address mismatch never drives `perrN` low, and a data mismatch never drives `serrN` low.
- R7: `detParErr` goes to 1 on the clock after any mismatch (address or data). It then stays at 1 until a clock edge where `statusClr`=1 and no new mismatch occurs. When a mismatch and `statusClr` come at the same edge, the flag stays set.
- R8: No check is made for clocks with `phaseValid`=0 or for phases the block sourced: whatever `parIn` carries on the clock after them, `perrN`, `serrN` and `detParErr` stay unchanged.
- R9: A received phase with correct parity leaves `perrN`=1, `serrN`=1 and `detParErr`=0.
- R10: While reset is active and right after it, `perrN`=1, `serrN`=1, `detParErr`=0 and `parOe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| phaseValid | input | 1 | An address phase or a completed data transfer happens on this clock |
| addrPhase | input | 1 | 1 = address phase, 0 = data phase |
| srcPhase | input | 1 | 1 = the block drives this phase, 0 = it receives it |
| adIn | input | 32 | Address/data word present on the bus |
| cbeIn | input | 4 | Command / byte-enable nibble present on the bus |
| parIn | input | 1 | Parity bit sampled from the bus (covers the previous phase) |
| perrRespEn | input | 1 | Command-register enable for data-parity error response |
| statusClr | input | 1 | Write-one-to-clear strobe for the detected-error flag |
| parOut | output | 1 | Parity bit to drive, valid while parOe=1 |
| parOe | output | 1 | Drive enable for parOut |
| perrN | output | 1 | Data parity error, active low, one clock per failing phase |
| serrN | output | 1 | System error from address parity, active low |
| detParErr | output | 1 | Sticky detected-parity-error status |

## Verification
The only internal state is the pending record of what the previous clock carried (sourced or received, address or data) and the stored parity. If that record is wrong, the effect appears on the ports within two clocks of the phase. One sign is a `parOe` pulse after a received phase. Another is a missing pulse after a sourced one. A third is an error pulse that lands on the wrong one of `perrN` and `serrN`. A stale stored parity gives an error on a correct phase on the clock after the parity clock. A stuck or leaking status flag shows up at the first clear strobe, or at the first quiet cycle after a mismatch.

// File: rtl/pci_parity_pkg.sv
package pci_parity_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic capture;   // latch parity of the current phase
    logic driveNow;  // drive the stored parity this clock
    logic compare;   // compare parIn against the stored parity this clock
  } parStrobe_t;

endpackage

// File: rtl/pci_parity_dp.sv
module pci_parity_dp
  import pci_parity_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] adIn,
  input  logic [LANES-1:0]  cbeIn,
  input  logic              parIn,
  input  parStrobe_t        strb,
  output logic              parOut,
  output logic              parOe,
  output logic              mismatch
);

  logic [LANES-1:0] lanePar;
  logic             phasePar;
  logic             storedPar;

  // One XOR group per byte lane, each folding in its byte-enable bit
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanePar[g] = (^adIn[8*g +: 8]) ^ cbeIn[g];
  end

  assign phasePar = ^lanePar;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storedPar <= 1'b0;
    end else if (strb.capture) begin
      storedPar <= phasePar;
    end
  end

  assign parOut   = storedPar;
  assign parOe    = strb.driveNow;
  assign mismatch = strb.compare && (parIn != storedPar);

endmodule

// File: rtl/pci_parity_ctl.sv
module pci_parity_ctl
  import pci_parity_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       phaseValid,
  input  logic       addrPhase,
  input  logic       srcPhase,
  input  logic       perrRespEn,
  input  logic       statusClr,
  input  logic       mismatch,
  output parStrobe_t strb,
  output logic       perrN,
  output logic       serrN,
  output logic       detParErr
);

  logic pendSrc;
  logic pendRcv;
  logic pendAddr;
  logic perrQ;
  logic serrQ;
  logic detQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSrc  <= 1'b0;
      pendRcv  <= 1'b0;
      pendAddr <= 1'b0;
      perrQ    <= 1'b0;
      serrQ    <= 1'b0;
      detQ     <= 1'b0;
    end else begin
      pendSrc  <= phaseValid && srcPhase;
      pendRcv  <= phaseValid && !srcPhase;
      pendAddr <= addrPhase;
      perrQ    <= mismatch && !pendAddr && perrRespEn;
      serrQ    <= mismatch && pendAddr;
      // a new mismatch wins over a simultaneous clear
      detQ     <= mismatch || (detQ && !statusClr);
    end
  end

  always_comb begin
    strb.capture  = phaseValid;
    strb.driveNow = pendSrc;
    strb.compare  = pendRcv;
  end

  assign perrN     = !perrQ;
  assign serrN     = !serrQ;
  assign detParErr = detQ;

endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
  import pci_parity_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              phaseValid,
  input  logic              addrPhase,
  input  logic              srcPhase,
  input  logic [DATA_W-1:0] adIn,
  input  logic [LANES-1:0]  cbeIn,
  input  logic              parIn,
  input  logic              perrRespEn,
  input  logic              statusClr,
  output logic              parOut,
  output logic              parOe,
  output logic              perrN,
  output logic              serrN,
  output logic              detParErr
);

  parStrobe_t strb;
  logic       mismatch;

  pci_parity_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .phaseValid (phaseValid),
    .addrPhase  (addrPhase),
    .srcPhase   (srcPhase),
    .perrRespEn (perrRespEn),
    .statusClr  (statusClr),
    .mismatch   (mismatch),
    .strb       (strb),
    .perrN      (perrN),
    .serrN      (serrN),
    .detParErr  (detParErr)
  );

  pci_parity_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .adIn     (adIn),
    .cbeIn    (cbeIn),
    .parIn    (parIn),
    .strb     (strb),
    .parOut   (parOut),
    .parOe    (parOe),
    .mismatch (mismatch)
  );

endmodule

// File: rtl/pci_parity_chk.sv
module pci_parity_chk #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              phaseValid,
  input logic              addrPhase,
  input logic              srcPhase,
  input logic [DATA_W-1:0] adIn,
  input logic [LANES-1:0]  cbeIn,
  input logic              perrRespEn,
  input logic              statusClr,
  input logic              parOut,
  input logic              parOe,
  input logic              perrN,
  input logic              serrN,
  input logic              detParErr
);

  // edges since reset release, saturating
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rstN) cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R1: drive enable follows a sourced phase with its even parity
  a_r1_drive_parity: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd1 && $past(phaseValid && srcPhase)) |->
      (parOe && parOut == ^{$past(adIn), $past(cbeIn)}));

  // R2: no drive without a sourced phase on the previous clock
  a_r2_no_spurious_oe: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd1 && !$past(phaseValid && srcPhase)) |-> !parOe);

  // R3: system error only two clocks after a received address phase
  a_r3_serr_source: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd2 && !serrN) |->
      ($past(phaseValid, 2) && $past(addrPhase, 2) && !$past(srcPhase, 2)));

  // R4: data error only after a received data phase with the enable set
  a_r4_perr_source: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd2 && !perrN) |->
      ($past(perrRespEn) && $past(phaseValid, 2) && !$past(addrPhase, 2)
       && !$past(srcPhase, 2)));

  // R6: the two error outputs never fire together
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!perrN && !serrN));

  // R7: any error pulse comes with the status flag set
  a_r7_status_set: assert property (@(posedge clk) disable iff (!rstN)
    (!perrN || !serrN) |-> detParErr);

  // R7: the status flag drops only on a clear strobe
  a_r7_status_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 2'd1 && $fell(detParErr)) |-> $past(statusClr));

endmodule

bind pci_parity_unit pci_parity_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .phaseValid (phaseValid),
  .addrPhase  (addrPhase),
  .srcPhase   (srcPhase),
  .adIn       (adIn),
  .cbeIn      (cbeIn),
  .perrRespEn (perrRespEn),
  .statusClr  (statusClr),
  .parOut     (parOut),
  .parOe      (parOe),
  .perrN      (perrN),
  .serrN      (serrN),
  .detParErr  (detParErr)
);

// File: tb/pci_parity_unit_tb.sv
module pci_parity_unit_tb;

  typedef struct packed {
    logic [31:0] ad;
    logic [3:0]  cbe;
    logic        isAddr;
    logic        src;
    logic        bad;
    logic        en;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{32'h1234_5678, 4'h6, 1'b1, 1'b0, 1'b0, 1'b1},  // addr rcv good
    '{32'hDEAD_BEEF, 4'h7, 1'b1, 1'b0, 1'b1, 1'b0},  // addr rcv bad, enable off
    '{32'hFFFF_FFFF, 4'h0, 1'b0, 1'b0, 1'b1, 1'b1},  // data rcv bad, enable on
    '{32'h0000_0001, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0},  // data rcv bad, enable off
    '{32'hA5A5_5A5A, 4'h3, 1'b0, 1'b0, 1'b0, 1'b1},  // data rcv good
    '{32'h8000_0000, 4'hB, 1'b1, 1'b1, 1'b0, 1'b1},  // addr sourced
    '{32'h0F0F_0F0F, 4'h1, 1'b0, 1'b1, 1'b1, 1'b1},  // data sourced, wrong bus parity
    '{32'h0000_0000, 4'h0, 1'b1, 1'b0, 1'b1, 1'b1}   // addr rcv bad, enable on
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        phaseValid, addrPhase, srcPhase, parIn, perrRespEn, statusClr;
  logic [31:0] adIn;
  logic [3:0]  cbeIn;
  logic        parOut, parOe, perrN, serrN, detParErr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pci_parity_unit u_dut (
    .clk(clk), .rstN(rstN), .phaseValid(phaseValid), .addrPhase(addrPhase),
    .srcPhase(srcPhase), .adIn(adIn), .cbeIn(cbeIn), .parIn(parIn),
    .perrRespEn(perrRespEn), .statusClr(statusClr), .parOut(parOut),
    .parOe(parOe), .perrN(perrN), .serrN(serrN), .detParErr(detParErr)
  );

  task automatic chk(input bit ok, input string req, input logic act, input logic expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, expv);
    end
  endtask

  task automatic quiet();
    phaseValid = 1'b0; addrPhase = 1'b0; srcPhase = 1'b0;
    adIn = '0; cbeIn = '0; parIn = 1'b0; statusClr = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic expPar, expPerr, expSerr, expDet;
    rstN = 1'b0; perrRespEn = 1'b0;
    quiet();
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(perrN == 1'b1, "R10 perrN", perrN, 1'b1);
    chk(serrN == 1'b1, "R10 serrN", serrN, 1'b1);
    chk(detParErr == 1'b0, "R10 detParErr", detParErr, 1'b0);
    chk(parOe == 1'b0, "R10 parOe", parOe, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk(parOe == 1'b0, "R10 parOe after release", parOe, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      phaseValid = 1'b1; addrPhase = VECS[i].isAddr; srcPhase = VECS[i].src;
      adIn = VECS[i].ad; cbeIn = VECS[i].cbe; perrRespEn = VECS[i].en; parIn = 1'b0;
      expPar = ^{VECS[i].ad, VECS[i].cbe};
      @(negedge clk);
      // R1 / R2: drive enable and parity value
      chk(parOe == VECS[i].src, "R1 R2 parOe", parOe, VECS[i].src);
      if (VECS[i].src) chk(parOut == expPar, "R1 parOut", parOut, expPar);
      phaseValid = 1'b0; parIn = expPar ^ VECS[i].bad;
      @(negedge clk);
      expSerr = !VECS[i].src && VECS[i].isAddr && VECS[i].bad;
      expPerr = !VECS[i].src && !VECS[i].isAddr && VECS[i].bad && VECS[i].en;
      expDet  = !VECS[i].src && VECS[i].bad;
      // R3 R4 R5 R6 R8 R9: error outputs
      chk(serrN == !expSerr, "R3 R6 R8 R9 serrN", serrN, !expSerr);
      chk(perrN == !expPerr, "R4 R5 R6 R8 R9 perrN", perrN, !expPerr);
      chk(detParErr == expDet, "R5 R7 R8 R9 detParErr", detParErr, expDet);
      chk(parOe == 1'b0, "R2 parOe idle", parOe, 1'b0);
      parIn = 1'b0; statusClr = 1'b1;
      @(negedge clk);
      statusClr = 1'b0;
      // R3 R4: one-clock pulse; R7: cleared
      chk(perrN == 1'b1, "R4 perr one clock", perrN, 1'b1);
      chk(serrN == 1'b1, "R3 serr one clock", serrN, 1'b1);
      chk(detParErr == 1'b0, "R7 cleared", detParErr, 1'b0);
    end

    // R8: garbage parity with no valid phase
    quiet();
    parIn = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(perrN && serrN && !detParErr, "R8 idle no error", detParErr, 1'b0);
    end

    // R7: set wins over a simultaneous clear, then the flag holds
    parIn = 1'b0;
    phaseValid = 1'b1; addrPhase = 1'b0; srcPhase = 1'b0; perrRespEn = 1'b1;
    adIn = 32'h0000_0003; cbeIn = 4'h0;  // even parity 0
    @(negedge clk);
    phaseValid = 1'b0; parIn = 1'b1; statusClr = 1'b1;
    @(negedge clk);
    statusClr = 1'b0; parIn = 1'b0;
    chk(detParErr == 1'b1, "R7 set wins over clear", detParErr, 1'b1);
    chk(perrN == 1'b0, "R4 perr with clear", perrN, 1'b0);
    repeat (3) @(negedge clk);
    chk(detParErr == 1'b1, "R7 sticky hold", detParErr, 1'b1);
    statusClr = 1'b1;
    @(negedge clk);
    statusClr = 1'b0;
    chk(detParErr == 1'b0, "R7 clear after hold", detParErr, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule